// File: doc/BRIEF.md
# Host Bridge Configuration Register Space

This block holds the 256-byte configuration space of a host-to-PCI bridge and serves it through a byte-wide access port. The port carries a function number, a register offset, write data, a write strobe, a read strobe and registered read data. Each byte follows one of three policies. Identification bytes are fixed and cannot be written. The upper status byte only lets software clear flags. Every other byte is plain storage. All bytes load fixed power-on values.

Three bytes select how the expansion and system ROM windows are routed. These are the shadow controls, split into 2-bit fields. They are driven to the memory routing logic together with the DRAM configuration and timing bytes. When a write changes one of the 2-bit shadow fields that name a routing region, the block raises a one-cycle update strobe for that region only. Rewriting the same value raises nothing. Only function 0 is implemented.

Top module: `hb_cfg_space`

## Requirements
- R1: After reset, function 0 reads these values: 0x06 at offset 0x00, 0x11 at 0x01, 0x85 at 0x02, 0x05 at 0x03, 0x00 at 0x08, 0x09 and 0x0A, and 0x06 at 0x0B. Offsets 0x0E and 0x0F read 0x00.
- R2: After reset, the command bytes read 0x07 at 0x04 and 0x00 at 0x05, and the status bytes read 0xA0 at 0x06 and 0x02 at 0x07.
- R3: After reset, offset 0x58 reads 0x40, 0x59 reads 0x05, each of 0x5A to 0x5F reads 0x01, and 0x64 reads 0xAB. The same values appear on `dram_cfg` and `dram_timing`.
- R4: Writes to offsets 0x00 to 0x03, 0x08 to 0x0B, 0x0E and 0x0F leave the stored bytes unchanged.
- R5: A write to offset 0x07 clears each stored bit that is set in both the write data and 0xB0. It never sets a bit. Bits outside 0xB0 keep their value, so after any write the byte still reads 0x02 under the mask 0x4F.
- R6: A read with a function number other than 0 returns 0xFF.
- R7: A write with a function number other than 0 changes no byte and raises no region strobe.
- R8: Every other offset is a plain read/write byte. Offsets with no reset value listed above reset to 0x00.
- R9: Read data is registered. It shows the addressed byte in the cycle after the read strobe and holds its value while no read is requested. It is 0x00 after reset.
- R10: A read and a write to the same offset in the same cycle return the value from before the write.
- R11: Writes to 0x61, 0x62 and 0x63 store the full byte. The byte appears on `shadow_ctl0`, `shadow_ctl1` or `shadow_ctl2` in the cycle after the write.
- R12: `region_upd` bit 4k+j (k = 0 for 0x61, k = 1 for 0x62, j = 0..3) pulses for one cycle, in the cycle after a write, when the write changes data bits [2j+1:2j] of that byte. For 0x63, bit 8 pulses when bits [5:4] change and bit 9 pulses when bits [7:6] change. A change in bits [3:0] of 0x63 raises nothing, and neither does rewriting an equal field.
- R13: `dram_cfg[8i+7:8i]` carries the byte at offset 0x58+i (i = 0..7) and `dram_timing` carries offset 0x64. Both follow writes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_func | input | 3 | Function number of the access |
| cfg_addr | input | 8 | Register offset |
| cfg_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write strobe |
| cfg_re | input | 1 | Read strobe |
| cfg_rdata | output | 8 | Registered read data |
| shadow_ctl0 | output | 8 | Shadow control byte, offset 0x61 |
| shadow_ctl1 | output | 8 | Shadow control byte, offset 0x62 |
| shadow_ctl2 | output | 8 | Shadow control byte, offset 0x63 |
| dram_cfg | output | 64 | DRAM configuration bytes 0x58..0x5F |
| dram_timing | output | 8 | DRAM timing byte 0x64 |
| region_upd | output | 10 | One-cycle routing-region update strobes |

## Verification
The hardest behaviour to reach from the ports is the write-one-to-clear status byte. Its masked bits reset to zero and no port can set them, so clearing can never be seen directly. The stimulus therefore writes all ones and all zeros to offset 0x07 and reads back the unmasked bits. A byte that had turned into plain storage, or that let writes set bits, then shows up. The change-only region strobes are driven in a similar way: a field is written, the identical byte is written again, and then only the low half of the third shadow byte is altered. A strobe that fires on every write, or on the wrong field, then becomes visible. A simultaneous read and write to one offset checks the old-value rule.

// File: rtl/hbcfg_pkg.sv
package hbcfg_pkg;

   localparam int unsigned CFG_BYTES = 256;

   localparam logic [7:0] OFF_STAT_HI  = 8'h07;
   localparam logic [7:0] STAT_W1C_MSK = 8'hB0;
   localparam logic [7:0] OFF_SHD0     = 8'h61;
   localparam logic [7:0] OFF_SHD1     = 8'h62;
   localparam logic [7:0] OFF_SHD2     = 8'h63;
   localparam int unsigned DRAM_BASE   = 32'h58;
   localparam int unsigned DRAM_BYTES  = 8;
   localparam int unsigned DRAM_TIMING = 32'h64;
   localparam int unsigned NUM_REGIONS = 10;

   typedef enum logic [1:0] {POL_RW, POL_RO, POL_W1C} byte_pol_e;

   function automatic byte_pol_e byte_policy(int unsigned idx);
      case (idx)
         32'h00, 32'h01, 32'h02, 32'h03,
         32'h08, 32'h09, 32'h0A, 32'h0B,
         32'h0E, 32'h0F:                 return POL_RO;
         32'h07:                         return POL_W1C;
         default:                        return POL_RW;
      endcase
   endfunction

   function automatic logic [7:0] byte_reset(int unsigned idx);
      case (idx)
         32'h00: return 8'h06;
         32'h01: return 8'h11;
         32'h02: return 8'h85;
         32'h03: return 8'h05;
         32'h04: return 8'h07;
         32'h06: return 8'hA0;
         32'h07: return 8'h02;
         32'h0B: return 8'h06;
         32'h58: return 8'h40;
         32'h59: return 8'h05;
         32'h5A, 32'h5B, 32'h5C,
         32'h5D, 32'h5E, 32'h5F: return 8'h01;
         32'h64: return 8'hAB;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/hbcfg_store.sv
module hbcfg_store
   import hbcfg_pkg::*;
#(
   parameter int unsigned AW     = 8,
   parameter int unsigned DW     = 8,
   parameter int unsigned NBYTES = CFG_BYTES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_idx,
   input  logic [DW-1:0]        wr_data,
   output logic [NBYTES*DW-1:0] q_flat
);

   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      localparam byte_pol_e  POL = byte_policy(i);
      localparam logic [DW-1:0] RV = DW'(byte_reset(i));
      if (POL == POL_RO) begin : g_ro
         assign q_flat[i*DW +: DW] = RV;
      end else if (POL == POL_W1C) begin : g_w1c
         logic [DW-1:0] r;
         always_ff @(posedge clk) begin
            if (!rst_n)
               r <= RV;
            else if (wr_en && wr_idx == AW'(i))
               r <= r & ~(wr_data & DW'(STAT_W1C_MSK));
         end
         assign q_flat[i*DW +: DW] = r;
      end else begin : g_rw
         logic [DW-1:0] r;
         always_ff @(posedge clk) begin
            if (!rst_n)
               r <= RV;
            else if (wr_en && wr_idx == AW'(i))
               r <= wr_data;
         end
         assign q_flat[i*DW +: DW] = r;
      end
   end

endmodule

// File: rtl/hbcfg_rdport.sv
module hbcfg_rdport #(
   parameter int unsigned AW     = 8,
   parameter int unsigned DW     = 8,
   parameter int unsigned FW     = 3,
   parameter int unsigned NBYTES = 256
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_en,
   input  logic [FW-1:0]        rd_func,
   input  logic [AW-1:0]        rd_idx,
   input  logic [NBYTES*DW-1:0] q_flat,
   output logic [DW-1:0]        rdata
);

   logic [DW-1:0] sel;

   always_comb begin
      if (rd_func != '0)
         sel = '1;
      else
         sel = q_flat[rd_idx*DW +: DW];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_en)
         rdata <= sel;
   end

endmodule

// File: rtl/hbcfg_region_evt.sv
module hbcfg_region_evt
   import hbcfg_pkg::*;
#(
   parameter int unsigned AW    = 8,
   parameter int unsigned DW    = 8,
   parameter int unsigned NREG  = NUM_REGIONS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_idx,
   input  logic [DW-1:0]   wr_data,
   input  logic [DW-1:0]   cur0,
   input  logic [DW-1:0]   cur1,
   input  logic [DW-1:0]   cur2,
   output logic [NREG-1:0] region_upd
);

   localparam int unsigned FIELDS = DW / 2;

   logic [NREG-1:0] chg;
   logic hit0, hit1, hit2;

   assign hit0 = wr_en && wr_idx == AW'(OFF_SHD0);
   assign hit1 = wr_en && wr_idx == AW'(OFF_SHD1);
   assign hit2 = wr_en && wr_idx == AW'(OFF_SHD2);

   for (genvar f = 0; f < FIELDS; f++) begin : g_fld
      assign chg[f]          = hit0 && (wr_data[2*f +: 2] != cur0[2*f +: 2]);
      assign chg[FIELDS + f] = hit1 && (wr_data[2*f +: 2] != cur1[2*f +: 2]);
   end
   assign chg[2*FIELDS]     = hit2 && (wr_data[5:4] != cur2[5:4]);
   assign chg[2*FIELDS + 1] = hit2 && (wr_data[7:6] != cur2[7:6]);

   always_ff @(posedge clk) begin
      if (!rst_n)
         region_upd <= '0;
      else
         region_upd <= chg;
   end

endmodule

// File: rtl/hb_cfg_space.sv
module hb_cfg_space
   import hbcfg_pkg::*;
#(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 8,
   parameter int unsigned FW = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [FW-1:0]              cfg_func,
   input  logic [AW-1:0]              cfg_addr,
   input  logic [DW-1:0]              cfg_wdata,
   input  logic                       cfg_we,
   input  logic                       cfg_re,
   output logic [DW-1:0]              cfg_rdata,
   output logic [DW-1:0]              shadow_ctl0,
   output logic [DW-1:0]              shadow_ctl1,
   output logic [DW-1:0]              shadow_ctl2,
   output logic [DRAM_BYTES*DW-1:0]   dram_cfg,
   output logic [DW-1:0]              dram_timing,
   output logic [NUM_REGIONS-1:0]     region_upd
);

   localparam int unsigned NBYTES = 1 << AW;

   if (AW != 8) begin : g_aw_bad
      $error("hb_cfg_space: AW must be 8");
   end
   if (DW != 8) begin : g_dw_bad
      $error("hb_cfg_space: DW must be 8");
   end
   if (FW < 1) begin : g_fw_bad
      $error("hb_cfg_space: FW must be at least 1");
   end

   logic                 wr_ok;
   logic [NBYTES*DW-1:0] q_flat;

   assign wr_ok = cfg_we && (cfg_func == '0);

   hbcfg_store #(.AW(AW), .DW(DW), .NBYTES(NBYTES)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ok),
      .wr_idx  (cfg_addr),
      .wr_data (cfg_wdata),
      .q_flat  (q_flat)
   );

   hbcfg_rdport #(.AW(AW), .DW(DW), .FW(FW), .NBYTES(NBYTES)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (cfg_re),
      .rd_func (cfg_func),
      .rd_idx  (cfg_addr),
      .q_flat  (q_flat),
      .rdata   (cfg_rdata)
   );

   assign shadow_ctl0 = q_flat[OFF_SHD0*DW +: DW];
   assign shadow_ctl1 = q_flat[OFF_SHD1*DW +: DW];
   assign shadow_ctl2 = q_flat[OFF_SHD2*DW +: DW];
   assign dram_cfg    = q_flat[DRAM_BASE*DW +: DRAM_BYTES*DW];
   assign dram_timing = q_flat[DRAM_TIMING*DW +: DW];

   hbcfg_region_evt #(.AW(AW), .DW(DW), .NREG(NUM_REGIONS)) u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_ok),
      .wr_idx     (cfg_addr),
      .wr_data    (cfg_wdata),
      .cur0       (shadow_ctl0),
      .cur1       (shadow_ctl1),
      .cur2       (shadow_ctl2),
      .region_upd (region_upd)
   );

endmodule

// File: rtl/hbcfg_chk.sv
module hbcfg_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] cfg_func,
   input logic [7:0] cfg_addr,
   input logic       cfg_we,
   input logic       cfg_re,
   input logic [7:0] cfg_rdata,
   input logic [7:0] shadow_ctl0,
   input logic [7:0] shadow_ctl1,
   input logic [7:0] shadow_ctl2,
   input logic [9:0] region_upd
);

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_re |=> $stable(cfg_rdata)); // R9

   AST_OTHER_FUNC_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_re && cfg_func != 3'd0) |=> cfg_rdata == 8'hFF); // R6

   AST_VENDOR_LOW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_re && cfg_func == 3'd0 && cfg_addr == 8'h00) |=> cfg_rdata == 8'h06); // R1

   AST_STATUS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_re && cfg_func == 3'd0 && cfg_addr == 8'h07) |=> (cfg_rdata & 8'h4F) == 8'h02); // R5

   AST_UPD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (region_upd != 10'd0) |-> $past(cfg_we && cfg_func == 3'd0 &&
         (cfg_addr == 8'h61 || cfg_addr == 8'h62 || cfg_addr == 8'h63))); // R12

   AST_SHADOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ($stable(shadow_ctl0) && $stable(shadow_ctl1) && $stable(shadow_ctl2))); // R11

endmodule

bind hb_cfg_space hbcfg_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_func    (cfg_func),
   .cfg_addr    (cfg_addr),
   .cfg_we      (cfg_we),
   .cfg_re      (cfg_re),
   .cfg_rdata   (cfg_rdata),
   .shadow_ctl0 (shadow_ctl0),
   .shadow_ctl1 (shadow_ctl1),
   .shadow_ctl2 (shadow_ctl2),
   .region_upd  (region_upd)
);

// File: tb/hb_cfg_space_tb.sv
module hb_cfg_space_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_func = '0;
   logic [7:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        cfg_we = 1'b0;
   logic        cfg_re = 1'b0;
   logic [7:0]  cfg_rdata;
   logic [7:0]  shadow_ctl0, shadow_ctl1, shadow_ctl2;
   logic [63:0] dram_cfg;
   logic [7:0]  dram_timing;
   logic [9:0]  region_upd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic rd_pipe = 1'b0;

   logic [7:0] mdl [256];
   logic [7:0] q_exp [$];
   string      q_tag [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   hb_cfg_space u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_func(cfg_func), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_rdata(cfg_rdata),
      .shadow_ctl0(shadow_ctl0), .shadow_ctl1(shadow_ctl1), .shadow_ctl2(shadow_ctl2),
      .dram_cfg(dram_cfg), .dram_timing(dram_timing), .region_upd(region_upd)
   );

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit is_ro(int a);
      return (a <= 3) || (a >= 8 && a <= 11) || a == 14 || a == 15;
   endfunction

   task automatic model_init();
      for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
      mdl[8'h00] = 8'h06; mdl[8'h01] = 8'h11; mdl[8'h02] = 8'h85; mdl[8'h03] = 8'h05;
      mdl[8'h04] = 8'h07; mdl[8'h06] = 8'hA0; mdl[8'h07] = 8'h02; mdl[8'h0B] = 8'h06;
      mdl[8'h58] = 8'h40; mdl[8'h59] = 8'h05; mdl[8'h64] = 8'hAB;
      for (int i = 8'h5A; i <= 8'h5F; i++) mdl[i] = 8'h01;
   endtask

   task automatic model_write(logic [2:0] f, logic [7:0] a, logic [7:0] d);
      if (f != 3'd0 || is_ro(a)) return;
      if (a == 8'h07) mdl[a] = mdl[a] & ~(d & 8'hB0);
      else mdl[a] = d;
   endtask

   // driver: one access per cycle; expected read data goes to the scoreboard
   task automatic access(logic [2:0] f, logic [7:0] a, logic [7:0] d,
                         bit we, bit re, string tag);
      cfg_func = f; cfg_addr = a; cfg_wdata = d; cfg_we = we; cfg_re = re;
      if (re) begin
         q_exp.push_back(f != 3'd0 ? 8'hFF : mdl[a]);
         q_tag.push_back(tag);
      end
      if (we) model_write(f, a, d);
      @(negedge clk);
      cfg_we = 1'b0; cfg_re = 1'b0;
   endtask

   task automatic wr(logic [2:0] f, logic [7:0] a, logic [7:0] d);
      access(f, a, d, 1'b1, 1'b0, "");
   endtask

   task automatic rd(logic [2:0] f, logic [7:0] a, string tag);
      access(f, a, 8'h00, 1'b0, 1'b1, tag);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: compare each registered read result one cycle after its request
   always @(posedge clk) rd_pipe <= rst_n && cfg_re;

   always @(negedge clk) begin
      if (rd_pipe) begin
         if (q_exp.size() == 0) begin
            check(1'b0, "R9 unexpected read data", cfg_rdata, 0);
         end else begin
            logic [7:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check(cfg_rdata === e, t, cfg_rdata, e);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_init();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state at the ports
      check(cfg_rdata === 8'h00, "R9 rdata after reset", cfg_rdata, 8'h00);
      check(dram_cfg === 64'h0101_0101_0101_0540, "R3 dram_cfg reset", dram_cfg, 64'h0101_0101_0101_0540);
      check(dram_timing === 8'hAB, "R3 dram_timing reset", dram_timing, 8'hAB);
      check(region_upd === 10'd0, "R12 no strobe after reset", region_upd, 0);

      foreach (mdl[i]) if (i <= 8'h0F) rd(3'd0, 8'(i), "R1 R2 identity/command/status reset");
      for (int i = 8'h58; i <= 8'h5F; i++) rd(3'd0, 8'(i), "R3 dram byte reset");
      rd(3'd0, 8'h64, "R3 dram timing reset");
      rd(3'd0, 8'h40, "R8 plain byte reset zero");
      rd(3'd0, 8'hFF, "R8 top byte reset zero");

      // read-only bytes
      wr(3'd0, 8'h00, 8'hFF); wr(3'd0, 8'h03, 8'h00); wr(3'd0, 8'h0B, 8'h00);
      wr(3'd0, 8'h09, 8'h5A); wr(3'd0, 8'h0E, 8'h77); wr(3'd0, 8'h0F, 8'h12);
      rd(3'd0, 8'h00, "R4 ro 0x00"); rd(3'd0, 8'h03, "R4 ro 0x03");
      rd(3'd0, 8'h0B, "R4 ro 0x0B"); rd(3'd0, 8'h09, "R4 ro 0x09");
      rd(3'd0, 8'h0E, "R4 ro 0x0E"); rd(3'd0, 8'h0F, "R4 ro 0x0F");

      // status clear-only byte
      wr(3'd0, 8'h07, 8'hFF); rd(3'd0, 8'h07, "R5 status after ones");
      wr(3'd0, 8'h07, 8'h00); rd(3'd0, 8'h07, "R5 status after zeros");

      // other functions
      rd(3'd3, 8'h00, "R6 func3 read"); rd(3'd1, 8'h40, "R6 func1 read");
      wr(3'd1, 8'h40, 8'h55); wr(3'd5, 8'h61, 8'hFF);
      check(region_upd === 10'd0, "R7 no strobe for func5 write", region_upd, 0);
      check(shadow_ctl0 === 8'h00, "R7 shadow unchanged by func5", shadow_ctl0, 0);
      rd(3'd0, 8'h40, "R7 func1 write ignored");

      // plain bytes
      for (int i = 8'h10; i < 8'h50; i++) wr(3'd0, 8'(i), 8'(i) ^ 8'h5A);
      for (int i = 8'h10; i < 8'h50; i++) rd(3'd0, 8'(i), "R8 plain byte sweep");
      wr(3'd0, 8'h04, 8'h00); rd(3'd0, 8'h04, "R8 command writable");
      wr(3'd0, 8'h06, 8'h3C); rd(3'd0, 8'h06, "R8 status low writable");

      // registered read holds
      rd(3'd0, 8'h58, "R9 read before hold");
      idle(2);
      check(cfg_rdata === 8'h40, "R9 rdata holds while idle", cfg_rdata, 8'h40);

      // same-cycle read and write
      access(3'd0, 8'h80, 8'h3C, 1'b1, 1'b1, "R10 old value on collision");
      rd(3'd0, 8'h80, "R10 new value next read");

      // shadow bytes and region strobes
      wr(3'd0, 8'h61, 8'h0C);
      check(region_upd === 10'h002, "R12 field1 of 0x61", region_upd, 10'h002);
      check(shadow_ctl0 === 8'h0C, "R11 shadow_ctl0", shadow_ctl0, 8'h0C);
      idle(1);
      check(region_upd === 10'h000, "R12 strobe one cycle", region_upd, 0);
      wr(3'd0, 8'h61, 8'h0C);
      check(region_upd === 10'h000, "R12 equal rewrite silent", region_upd, 0);
      wr(3'd0, 8'h62, 8'hC3);
      check(region_upd === 10'h090, "R12 fields 0 and 3 of 0x62", region_upd, 10'h090);
      check(shadow_ctl1 === 8'hC3, "R11 shadow_ctl1", shadow_ctl1, 8'hC3);
      wr(3'd0, 8'h63, 8'h0F);
      check(region_upd === 10'h000, "R12 low half of 0x63 silent", region_upd, 0);
      check(shadow_ctl2 === 8'h0F, "R11 shadow_ctl2 full byte", shadow_ctl2, 8'h0F);
      wr(3'd0, 8'h63, 8'h3F);
      check(region_upd === 10'h100, "R12 bits 5:4 of 0x63", region_upd, 10'h100);
      wr(3'd0, 8'h63, 8'hFF);
      check(region_upd === 10'h200, "R12 bits 7:6 of 0x63", region_upd, 10'h200);
      rd(3'd0, 8'h63, "R11 shadow readback");

      // dram outputs
      wr(3'd0, 8'h5A, 8'h22);
      check(dram_cfg[23:16] === 8'h22, "R13 dram_cfg byte 2", dram_cfg[23:16], 8'h22);
      wr(3'd0, 8'h64, 8'h11);
      check(dram_timing === 8'h11, "R13 dram_timing", dram_timing, 8'h11);
      rd(3'd0, 8'h5A, "R13 dram readback");

      idle(3);
      check(q_exp.size() == 0, "R9 all reads answered", q_exp.size(), 0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule